// File: doc/BRIEF.md
# Looped Stream Integrity Checker

This block confirms that a 16-bit stream sent out on a transmit AXI4-Stream interface returns unchanged on a receive AXI4-Stream interface after an external loop. The transmit stream, the receive stream and the comparison each run on their own clock. On each stream side, samples are taken only on beats where the valid signal is high. Four samples are gathered into one 64-bit word, and that word is written into a clock-crossing FIFO owned by that side.

In the compare domain, the block removes one word from each FIFO in the same cycle, but only when both FIFOs hold data. It then reports the pair of words and whether they differ. It keeps 32-bit counts of compared words and of mismatched words. It also keeps sticky flags for mismatches and for dropped words.

The loop has latency, so the transmit FIFO normally holds more entries than the receive FIFO. This is expected and is not treated as an error. The block handles no packet framing, checksum or alignment search.

Top module: `loop_integrity_checker`

## Requirements
- R1: A stream sample is captured only on a rising edge of that side's clock where its tvalid is 1. tdata on beats with tvalid at 0 has no effect on any word.
- R2: Four captured samples form one 64-bit word, with the first sample in bits [15:0] and the fourth in bits [63:48]. For example, 0x8AF0, 0x19B6, 0x73E4, 0x25CD give 0x25CD73E419B68AF0.
- R3: The transmit and receive sides each write their own FIFO on their own clock. Words are compared in the order in which each side formed them.
- R4: A compare happens only in a cmp_clk cycle where both FIFOs are non-empty, and that cycle removes exactly one word from each FIFO. The result appears on cmp_valid, cmp_tx_word and cmp_rx_word one cmp_clk cycle later.
- R5: cmp_mismatch is 1 together with cmp_valid whenever the two compared words differ in any bit. err_flag then becomes 1 and stays 1 until clear.
- R6: Words waiting in the transmit FIFO with no receive partner cause no compare, no count change and no error.
- R7: word_cnt increases by one per compare, and err_cnt increases by one per mismatching compare. Both counters are 32 bits wide.
- R8: A word formed while its side's FIFO is full is dropped, and ovf_flag becomes 1 and stays 1 until clear. Words already stored are kept, and each FIFO holds FIFO_DEPTH words (default 16).
- R9: Asserting tx_pack_clr or rx_pack_clr for a cycle discards that side's partly gathered word. A beat in the same cycle is also discarded, and the next valid beat becomes sample 0 of a new word.
- R10: clear, when sampled at 1 on a cmp_clk edge, sets word_cnt, err_cnt, err_flag and ovf_flag to 0.
- R11: After reset (tx_rst, rx_rst and cmp_rst held at 1 over several edges of each clock, synchronous, active high), all counters and flags read 0 and cmp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit stream clock |
| tx_rst | input | 1 | Synchronous reset, transmit domain |
| tx_pack_clr | input | 1 | Discard partial transmit word |
| tx_tvalid | input | 1 | Transmit beat valid |
| tx_tdata | input | 16 | Transmit sample |
| rx_clk | input | 1 | Receive stream clock |
| rx_rst | input | 1 | Synchronous reset, receive domain |
| rx_pack_clr | input | 1 | Discard partial receive word |
| rx_tvalid | input | 1 | Receive beat valid |
| rx_tdata | input | 16 | Receive sample |
| cmp_clk | input | 1 | Compare domain clock |
| cmp_rst | input | 1 | Synchronous reset, compare domain |
| clear | input | 1 | Zero counters and sticky flags |
| cmp_valid | output | 1 | A compare result is present |
| cmp_mismatch | output | 1 | The compared words differ |
| cmp_tx_word | output | 64 | Transmit word of the last compare |
| cmp_rx_word | output | 64 | Receive word of the last compare |
| err_flag | output | 1 | Sticky mismatch flag |
| ovf_flag | output | 1 | Sticky dropped-word flag |
| word_cnt | output | 32 | Compared word count |
| err_cnt | output | 32 | Mismatched word count |

## Verification
The assertions check several properties on every cycle:
- a word leaves the packer only after a valid beat, and its top lane holds that beat's data;
- a full FIFO never moves its write pointer;
- a FIFO is never read while empty;
- the error flag stays set until clear;
- the counters move by exactly the number of compares and mismatches.

Some behaviours can only be shown by the bench scenarios:
- lane order against a known example;
- invalid beats being ignored;
- transmit-ahead traffic causing no error;
- words dropped on overflow;
- partial words discarded by the pack clear.

// File: rtl/loopchk_pkg.sv
package loopchk_pkg;

    localparam int SAMPLE_W = 16;
    localparam int LANES    = 4;
    localparam int WORD_W   = SAMPLE_W * LANES;
    localparam int LANE_IW  = $clog2(LANES);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [WORD_W-1:0]   word_t;

    typedef struct packed {
        logic  valid;
        logic  mismatch;
        word_t tx;
        word_t rx;
    } cmp_result_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/lc_packer.sv
module lc_packer
    import loopchk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    in_vld,
    input  sample_t in_data,
    output logic    out_vld,
    output word_t   out_word
);
    logic [LANE_IW-1:0] lane;
    word_t              acc;
    word_t              merged;

    always_comb begin
        merged = acc;
        merged[lane*SAMPLE_W +: SAMPLE_W] = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lane     <= '0;
            acc      <= '0;
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            out_vld <= 1'b0;
            if (in_vld) begin
                acc  <= merged;
                lane <= lane + 1'b1;
                if (lane == LANE_IW'(LANES - 1)) begin
                    out_vld  <= 1'b1;
                    out_word <= merged;
                end
            end
        end
    end

    AST_BEAT_ONLY: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($past(in_vld) && !$past(clr)));  // R1
    AST_LAST_LANE: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_word[WORD_W-1 -: SAMPLE_W] == $past(in_data)));  // R2

endmodule

// File: rtl/lc_async_fifo.sv
module lc_async_fifo
    import loopchk_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 16
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    output logic          full,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          ren,
    output logic [DW-1:0] rdata,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, wbin_nx;
    logic [PW-1:0] rbin, rgray, rbin_nx;
    logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
    logic          wr_ok, rd_ok;

    assign wr_ok   = wen && !full;
    assign rd_ok   = ren && !empty;
    assign wbin_nx = wbin + PW'(wr_ok);
    assign rbin_nx = rbin + PW'(rd_ok);

    // write domain
    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= PW'(bin2gray(32'(wbin_nx)));
            rg_s1 <= rgray;
            rg_s2 <= rg_s1;
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_ok) mem[wbin[AW-1:0]] <= wdata;
    end

    assign full = (wgray == {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});

    // read domain
    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            wg_s1 <= '0;
            wg_s2 <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= PW'(bin2gray(32'(rbin_nx)));
            wg_s1 <= wgray;
            wg_s2 <= wg_s1;
        end
    end

    assign empty = (rgray == wg_s2);
    assign rdata = mem[rbin[AW-1:0]];

    AST_FULL_HOLDS: assert property (@(posedge wclk) disable iff (wrst)
        (wen && full) |=> (wbin == $past(wbin)));  // R8
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rrst)
        ren |-> !empty);  // R4

endmodule

// File: rtl/lc_evt_sync.sv
module lc_evt_sync (
    input  logic src_clk,
    input  logic src_rst,
    input  logic evt,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic pulse
);
    logic       tgl;
    logic [2:0] q;

    always_ff @(posedge src_clk) begin
        if (src_rst) tgl <= 1'b0;
        else if (evt) tgl <= ~tgl;
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) q <= '0;
        else         q <= {q[1:0], tgl};
    end

    assign pulse = q[2] ^ q[1];

endmodule

// File: rtl/lc_compare.sv
module lc_compare
    import loopchk_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tx_empty,
    input  logic             rx_empty,
    input  word_t            tx_word,
    input  word_t            rx_word,
    input  logic             ovf_evt,
    output logic             pop,
    output cmp_result_t      res,
    output logic [CNT_W-1:0] word_cnt,
    output logic [CNT_W-1:0] err_cnt,
    output logic             err_flag,
    output logic             ovf_flag
);
    logic diff;

    assign pop  = !tx_empty && !rx_empty;
    assign diff = pop && (tx_word != rx_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            res      <= '0;
            word_cnt <= '0;
            err_cnt  <= '0;
            err_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            res.valid    <= pop;
            res.mismatch <= diff;
            if (pop) begin
                res.tx <= tx_word;
                res.rx <= rx_word;
            end
            if (clear) begin
                word_cnt <= '0;
                err_cnt  <= '0;
                err_flag <= 1'b0;
                ovf_flag <= 1'b0;
            end else begin
                if (pop)     word_cnt <= word_cnt + 1'b1;
                if (diff)    err_cnt  <= err_cnt + 1'b1;
                if (diff)    err_flag <= 1'b1;
                if (ovf_evt) ovf_flag <= 1'b1;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clear) |=> err_flag);  // R5
    AST_MISMATCH_IN_CMP: assert property (@(posedge clk) disable iff (rst)
        res.mismatch |-> res.valid);  // R5
    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (word_cnt == $past(word_cnt) + CNT_W'(res.valid)));  // R7
    AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (err_cnt == $past(err_cnt) + CNT_W'(res.mismatch)));  // R7

endmodule

// File: rtl/loop_integrity_checker.sv
module loop_integrity_checker
    import loopchk_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 32
) (
    input  logic              tx_clk,
    input  logic              tx_rst,
    input  logic              tx_pack_clr,
    input  logic              tx_tvalid,
    input  logic [15:0]       tx_tdata,
    input  logic              rx_clk,
    input  logic              rx_rst,
    input  logic              rx_pack_clr,
    input  logic              rx_tvalid,
    input  logic [15:0]       rx_tdata,
    input  logic              cmp_clk,
    input  logic              cmp_rst,
    input  logic              clear,
    output logic              cmp_valid,
    output logic              cmp_mismatch,
    output logic [63:0]       cmp_tx_word,
    output logic [63:0]       cmp_rx_word,
    output logic              err_flag,
    output logic              ovf_flag,
    output logic [CNT_W-1:0]  word_cnt,
    output logic [CNT_W-1:0]  err_cnt
);
    localparam int SIDES = 2;  // index 0 transmit, 1 receive

    logic [SIDES-1:0] s_clk, s_rst, s_clr, s_vld;
    logic [SIDES-1:0] s_wvld, s_full, s_empty, s_ovf;
    sample_t          s_data  [SIDES];
    word_t            s_word  [SIDES];
    word_t            s_rdata [SIDES];
    logic             pop;
    cmp_result_t      res;

    assign s_clk     = {rx_clk, tx_clk};
    assign s_rst     = {rx_rst, tx_rst};
    assign s_clr     = {rx_pack_clr, tx_pack_clr};
    assign s_vld     = {rx_tvalid, tx_tvalid};
    assign s_data[0] = tx_tdata;
    assign s_data[1] = rx_tdata;

    for (genvar i = 0; i < SIDES; i++) begin : g_side
        lc_packer u_pack (
            .clk      (s_clk[i]),
            .rst      (s_rst[i]),
            .clr      (s_clr[i]),
            .in_vld   (s_vld[i]),
            .in_data  (s_data[i]),
            .out_vld  (s_wvld[i]),
            .out_word (s_word[i])
        );

        lc_async_fifo #(
            .DW    (WORD_W),
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .wclk  (s_clk[i]),
            .wrst  (s_rst[i]),
            .wen   (s_wvld[i]),
            .wdata (s_word[i]),
            .full  (s_full[i]),
            .rclk  (cmp_clk),
            .rrst  (cmp_rst),
            .ren   (pop),
            .rdata (s_rdata[i]),
            .empty (s_empty[i])
        );

        lc_evt_sync u_ovf (
            .src_clk (s_clk[i]),
            .src_rst (s_rst[i]),
            .evt     (s_wvld[i] && s_full[i]),
            .dst_clk (cmp_clk),
            .dst_rst (cmp_rst),
            .pulse   (s_ovf[i])
        );
    end

    lc_compare #(
        .CNT_W (CNT_W)
    ) u_cmp (
        .clk      (cmp_clk),
        .rst      (cmp_rst),
        .clear    (clear),
        .tx_empty (s_empty[0]),
        .rx_empty (s_empty[1]),
        .tx_word  (s_rdata[0]),
        .rx_word  (s_rdata[1]),
        .ovf_evt  (|s_ovf),
        .pop      (pop),
        .res      (res),
        .word_cnt (word_cnt),
        .err_cnt  (err_cnt),
        .err_flag (err_flag),
        .ovf_flag (ovf_flag)
    );

    assign cmp_valid    = res.valid;
    assign cmp_mismatch = res.mismatch;
    assign cmp_tx_word  = res.tx;
    assign cmp_rx_word  = res.rx;

endmodule

// File: tb/loop_integrity_checker_test.sv
`timescale 1ns/1ps
module loop_integrity_checker_test;

    localparam int DEPTH = 16;

    logic        tx_clk = 0, rx_clk = 0, cmp_clk = 0;
    logic        tx_rst = 1, rx_rst = 1, cmp_rst = 1;
    logic        tx_pack_clr = 0, rx_pack_clr = 0, clear = 0;
    logic        tx_tvalid = 0, rx_tvalid = 0;
    logic [15:0] tx_tdata = 0, rx_tdata = 0;
    logic        cmp_valid, cmp_mismatch, err_flag, ovf_flag;
    logic [63:0] cmp_tx_word, cmp_rx_word;
    logic [31:0] word_cnt, err_cnt;

    int checks = 0, errors = 0, seen_cmp = 0;
    bit done = 0;
    logic [63:0] exp_tx_q[$], exp_rx_q[$];
    logic [63:0] last_tx = '0, last_rx = '0;

    always #2   cmp_clk = ~cmp_clk;   // 250 MHz
    always #3   tx_clk  = ~tx_clk;
    always #3.5 rx_clk  = ~rx_clk;

    loop_integrity_checker #(.FIFO_DEPTH(DEPTH)) uut (
        .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_pack_clr(tx_pack_clr),
        .tx_tvalid(tx_tvalid), .tx_tdata(tx_tdata),
        .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_pack_clr(rx_pack_clr),
        .rx_tvalid(rx_tvalid), .rx_tdata(rx_tdata),
        .cmp_clk(cmp_clk), .cmp_rst(cmp_rst), .clear(clear),
        .cmp_valid(cmp_valid), .cmp_mismatch(cmp_mismatch),
        .cmp_tx_word(cmp_tx_word), .cmp_rx_word(cmp_rx_word),
        .err_flag(err_flag), .ovf_flag(ovf_flag),
        .word_cnt(word_cnt), .err_cnt(err_cnt)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_tx(input logic [63:0] w, input int gaps, input bit keep);
        if (keep) exp_tx_q.push_back(w);
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < gaps; g++) begin
                @(negedge tx_clk); tx_tvalid = 0; tx_tdata = 16'hDEAD ^ 16'(g);
            end
            @(negedge tx_clk); tx_tvalid = 1; tx_tdata = w[k*16 +: 16];
        end
        @(negedge tx_clk); tx_tvalid = 0; tx_tdata = 16'hBEEF;
    endtask

    task automatic send_rx(input logic [63:0] w, input int gaps, input bit keep);
        if (keep) exp_rx_q.push_back(w);
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < gaps; g++) begin
                @(negedge rx_clk); rx_tvalid = 0; rx_tdata = 16'hF00D ^ 16'(g);
            end
            @(negedge rx_clk); rx_tvalid = 1; rx_tdata = w[k*16 +: 16];
        end
        @(negedge rx_clk); rx_tvalid = 0; rx_tdata = 16'h1234;
    endtask

    task automatic settle();
        repeat (40) @(negedge cmp_clk);
    endtask

    function automatic logic [63:0] pat(input int i);
        return 64'hC0DE_0000_0000_0000 | (64'(i) * 64'h0000_0001_0001_0001);
    endfunction

    // monitor: scoreboard pop on every reported compare
    always @(negedge cmp_clk) begin
        if (!cmp_rst && cmp_valid) begin
            seen_cmp++;
            if (exp_tx_q.size() == 0 || exp_rx_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4 unexpected compare: actual tx %h rx %h expected none",
                         cmp_tx_word, cmp_rx_word);
            end else begin
                logic [63:0] et, er;
                et = exp_tx_q.pop_front();
                er = exp_rx_q.pop_front();
                check("R3", "tx word order", cmp_tx_word, et);
                check("R2", "rx word packing", cmp_rx_word, er);
                check("R5", "mismatch bit", 64'(cmp_mismatch), 64'(et != er));
                last_tx = cmp_tx_word;
                last_rx = cmp_rx_word;
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (20) @(negedge cmp_clk);
        tx_rst = 0; rx_rst = 0; cmp_rst = 0;
        @(negedge cmp_clk);
        // R11: reset state
        check("R11", "word_cnt", 64'(word_cnt), 0);
        check("R11", "err_cnt", 64'(err_cnt), 0);
        check("R11", "err_flag", 64'(err_flag), 0);
        check("R11", "ovf_flag", 64'(ovf_flag), 0);
        check("R11", "cmp_valid", 64'(cmp_valid), 0);

        // R2 example packing, R1 invalid beats with garbage data
        fork
            begin send_tx(64'h25CD_73E4_19B6_8AF0, 0, 1); send_tx(64'h0123_4567_89AB_CDEF, 2, 1); end
            begin send_rx(64'h25CD_73E4_19B6_8AF0, 0, 1); send_rx(64'h0123_4567_89AB_CDEF, 1, 1); end
        join
        settle();
        check("R1", "gapped word", last_rx, 64'h0123_4567_89AB_CDEF);
        check("R7", "word_cnt", 64'(word_cnt), 2);
        check("R1", "err_cnt", 64'(err_cnt), 0);

        // R6 / R4: transmit runs ahead
        base = seen_cmp;
        for (int i = 0; i < 3; i++) send_tx(pat(100 + i), 0, 1);
        settle();
        check("R4", "compares while rx empty", 64'(seen_cmp - base), 0);
        check("R6", "word_cnt", 64'(word_cnt), 2);
        check("R6", "err_flag", 64'(err_flag), 0);
        for (int i = 0; i < 3; i++) send_rx(pat(100 + i), 0, 1);
        settle();
        check("R3", "word_cnt after catch-up", 64'(word_cnt), 5);
        check("R6", "err_cnt", 64'(err_cnt), 0);

        // R5 single-bit mismatch, then a clean pair
        fork
            send_tx(64'hAAAA_5555_AAAA_5555, 0, 1);
            send_rx(64'hAAAA_5555_AAAA_5555 ^ (64'd1 << 37), 0, 1);
        join
        settle();
        check("R5", "err_flag", 64'(err_flag), 1);
        check("R7", "err_cnt", 64'(err_cnt), 1);
        check("R7", "word_cnt", 64'(word_cnt), 6);
        fork
            send_tx(pat(7), 0, 1);
            send_rx(pat(7), 0, 1);
        join
        settle();
        check("R5", "err_flag sticky", 64'(err_flag), 1);
        check("R7", "err_cnt steady", 64'(err_cnt), 1);
        check("R7", "word_cnt", 64'(word_cnt), 7);

        // R10 clear
        @(negedge cmp_clk); clear = 1;
        @(negedge cmp_clk); clear = 0;
        check("R10", "word_cnt", 64'(word_cnt), 0);
        check("R10", "err_cnt", 64'(err_cnt), 0);
        check("R10", "err_flag", 64'(err_flag), 0);

        // R9 pack clear discards a partial word and a same-cycle beat
        fork
            begin
                @(negedge tx_clk); tx_tvalid = 1; tx_tdata = 16'hAAAA;
                @(negedge tx_clk); tx_tdata = 16'hBBBB;
                @(negedge tx_clk); tx_pack_clr = 1; tx_tdata = 16'hCCCC;
                @(negedge tx_clk); tx_pack_clr = 0; tx_tvalid = 0;
                send_tx(64'h9999_8888_7777_6666, 0, 1);
            end
            send_rx(64'h9999_8888_7777_6666, 0, 1);
        join
        settle();
        check("R9", "word_cnt", 64'(word_cnt), 1);
        check("R9", "err_cnt", 64'(err_cnt), 0);
        check("R9", "aligned word", last_tx, 64'h9999_8888_7777_6666);

        // R8 overflow: DEPTH+2 words into an empty transmit FIFO
        for (int i = 0; i < DEPTH + 2; i++) send_tx(pat(i), 0, i < DEPTH);
        settle();
        check("R8", "ovf_flag", 64'(ovf_flag), 1);
        check("R8", "word_cnt before rx", 64'(word_cnt), 1);
        for (int i = 0; i < DEPTH; i++) send_rx(pat(i), 0, 1);
        settle();
        check("R8", "word_cnt after drain", 64'(word_cnt), 64'(1 + DEPTH));
        check("R8", "err_cnt", 64'(err_cnt), 0);
        check("R3", "tx queue drained", 64'(exp_tx_q.size()), 0);
        send_rx(pat(DEPTH), 0, 0);
        settle();
        check("R8", "dropped words absent", 64'(word_cnt), 64'(1 + DEPTH));

        // R10 clear of overflow flag and counters
        @(negedge cmp_clk); clear = 1;
        @(negedge cmp_clk); clear = 0;
        check("R10", "ovf_flag", 64'(ovf_flag), 0);
        check("R10", "word_cnt", 64'(word_cnt), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule